// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a synchronous host and an asynchronous, four-bit-wide EDO DRAM whose address pins are shared between row and column. The host offers one word at a time through a valid/ready request carrying a 22-bit word address, a write flag and write data. The controller produces the row strobe, column strobe, write enable, output enable and the shared 11-bit address. It drives the data bus during writes and samples it during reads. Each finished read returns its word with a single-cycle `rd_valid` pulse. Every analog timing limit is a parameter counted in controller clocks, each rounded up from nanoseconds.

After an access the row stays open. A later request to the same row runs as a column-only page cycle: the row strobe stays low and only the column strobe pulses. A request to another row first closes the open row, then waits out the row precharge before the new row is strobed. A row is also closed when a refresh owner raises `ref_grant`, and when the row has been open for `T_OPEN_MAX` clocks. The controller acknowledges a grant only once its strobes are parked high and precharge has elapsed.

Back-pressure: a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The host must hold address, flag and data stable until that edge. `req_ready` is high only while the controller is idle, no grant is present and the open row has not aged out. Read results cannot be stalled, so the host must always accept `rd_valid`.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset all four strobes are high, `dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: The row is the upper 11 bits of `req_addr` and is on `mem_addr` when the row strobe falls. The column is the lower 11 bits and is on `mem_addr` when the column strobe falls. The column strobe is only ever low while the row strobe is low.
- R3: Each accepted read yields exactly one single-cycle `rd_valid` pulse, in request order. Its data is the word most recently written to that address, or the array's prior content.
- R4: Read data is sampled on the edge that raises the column strobe. That edge comes only after the column strobe has been low for at least max(`T_CAC`, `T_AA`, `T_OEA`) clocks and the row strobe for at least `T_RAC` clocks.
- R5: Writes are early writes. Write enable is low and the write data is driven (`dq_oe` high) at least one clock before the column strobe falls. Output enable stays high throughout the write, and `dq_oe` is never high while output enable is low.
- R6: Once the row strobe falls, it stays low for at least `T_RAS` clocks.
- R7: The row strobe stays high for at least `T_RP` clocks before it falls. The column strobe stays high for at least `T_CP` clocks before it falls.
- R8: A request to the currently open row produces no row strobe transition.
- R9: A request to a different row raises the row strobe, then lowers it again with the new row on the address pins.
- R10: While `ref_grant` is high, `req_ready` is low. `ref_ack` rises only with both strobes high, no row open and precharge met.
- R11: A row is not held open longer than `T_OPEN_MAX` clocks plus the length of one access. An idle open row is closed after `T_OPEN_MAX` clocks.
- R12: `req_ready` is low from acceptance until the access completes, and never high while the column strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 22 | Word address, row in the upper half |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | Single-cycle read result strobe |
| rd_data | output | 4 | Read result |
| ref_grant | input | 1 | Refresh owner requests the DRAM |
| ref_ack | output | 1 | DRAM parked and precharged for refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 11 | Shared row/column address |
| dq_out | output | 4 | Data toward the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 4 | Data from the DRAM |

## Verification
The bench keeps the default 50 MHz timing counts except for two overrides. `T_RAC` is raised to 5, so the row access time, rather than the column access time, gates the first read after a row opens; this makes an early sample visible as wrong data. `T_OPEN_MAX` is lowered to 64, so the age-out close is reached within a short idle gap. Its DRAM model returns inverted data whenever a read is sampled before every access count is met, and it counts strobe edges to show whether a row was reopened.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_PRECH,
    ST_PREP,
    ST_ARM,
    ST_COL
  } edo_state_e;

  localparam int TI_RAS   = 0;  // cycles since row strobe fell
  localparam int TI_RP    = 1;  // cycles since row strobe rose
  localparam int TI_CP    = 2;  // cycles since column strobe rose
  localparam int TI_COL   = 3;  // cycles since column strobe fell
  localparam int N_TIMERS = 4;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_span_counter.sv
module edo_span_counter #(
  parameter int unsigned LIMIT = 15,
  parameter int unsigned W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  // count = clocks that will have elapsed at the next edge since the restart edge
  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (restart)        count <= W'(1);
    else if (count != TOP)   count <= count + 1'b1;
  end
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic [ROW_W-1:0] probe_row_i,
  output logic             is_open_o,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open_o <= 1'b0;
      row_q     <= '0;
    end else if (open_i) begin
      is_open_o <= 1'b1;
      row_q     <= open_row_i;
    end else if (close_i) begin
      is_open_o <= 1'b0;
    end
  end

  assign hit_o = is_open_o && (row_q == probe_row_i);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W      = 11,
  parameter int unsigned COL_W      = 11,
  parameter int unsigned DQ_W       = 4,
  parameter int unsigned T_RAC      = 3,
  parameter int unsigned T_CAC      = 1,
  parameter int unsigned T_AA       = 2,
  parameter int unsigned T_OEA      = 1,
  parameter int unsigned T_RAS      = 3,
  parameter int unsigned T_RP       = 2,
  parameter int unsigned T_CP       = 1,
  parameter int unsigned T_RCD      = 1,
  parameter int unsigned T_CASW     = 1,
  parameter int unsigned T_OPEN_MAX = 500,
  localparam int unsigned ADDR_W    = ROW_W + COL_W,
  localparam int unsigned PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  input  logic              ref_grant,
  output logic              ref_ack,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [PIN_W-1:0]  mem_addr,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  input  logic [DQ_W-1:0]   dq_in
);
  localparam int unsigned COL_ACC = umax(umax(T_CAC, T_AA), T_OEA);
  localparam int unsigned CNT_MAX = umax(umax(umax(T_OPEN_MAX, T_RAC), umax(T_RAS, T_RP)),
                                         umax(umax(T_CP, T_RCD), umax(T_CASW, COL_ACC)));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] L_RAC  = CNT_W'(T_RAC);
  localparam logic [CNT_W-1:0] L_COL  = CNT_W'(COL_ACC);
  localparam logic [CNT_W-1:0] L_RAS  = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] L_RP   = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] L_CP   = CNT_W'(T_CP);
  localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] L_CASW = CNT_W'(T_CASW);
  localparam logic [CNT_W-1:0] L_OPEN = CNT_W'(T_OPEN_MAX);

  // ---------------- interval timers ----------------
  logic [N_TIMERS-1:0] tmr_restart;
  logic [CNT_W-1:0]    tmr_cnt [N_TIMERS];

  generate
    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
      edo_span_counter #(.LIMIT(CNT_MAX), .W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart[g]),
        .count   (tmr_cnt[g])
      );
    end
  endgenerate

  logic [CNT_W-1:0] ras_cnt, rp_cnt, cp_cnt, col_cnt;
  assign ras_cnt = tmr_cnt[TI_RAS];
  assign rp_cnt  = tmr_cnt[TI_RP];
  assign cp_cnt  = tmr_cnt[TI_CP];
  assign col_cnt = tmr_cnt[TI_COL];

  // ---------------- open row ----------------
  logic [ROW_W-1:0] req_row, lat_row;
  logic [COL_W-1:0] req_col, lat_col;
  logic             lat_we;
  logic [DQ_W-1:0]  lat_wdata;
  logic             row_set, row_clr, row_open, row_hit;

  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  edo_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_i      (row_set),
    .close_i     (row_clr),
    .open_row_i  (lat_row),
    .probe_row_i (req_row),
    .is_open_o   (row_open),
    .hit_o       (row_hit)
  );

  // ---------------- sequencer ----------------
  edo_state_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic             ras_d, cas_d, we_d, oe_d, dqoe_d, rdv_d;
  logic [PIN_W-1:0] addr_d;
  logic [DQ_W-1:0]  dqo_d, rdd_d;
  logic             take, aged;

  assign aged      = row_open && (ras_cnt >= L_OPEN);
  assign req_ready = (st_q == ST_IDLE) && !ref_grant && !aged;
  assign take      = req_valid && req_ready;
  assign ref_ack   = (st_q == ST_IDLE) && ref_grant && !row_open && (rp_cnt >= L_RP);

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q;
    ras_d       = ras_n;
    cas_d       = cas_n;
    we_d        = we_n;
    oe_d        = oe_n;
    addr_d      = mem_addr;
    dqoe_d      = dq_oe;
    dqo_d       = dq_out;
    rdv_d       = 1'b0;
    rdd_d       = rd_data;
    tmr_restart = '0;
    row_set     = 1'b0;
    row_clr     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (row_open && (ref_grant || aged)) begin
          st_d   = ST_CLOSE;
          pend_d = 1'b0;
        end else if (take) begin
          if (!row_open) begin
            st_d   = ST_PRECH;
            addr_d = PIN_W'(req_row);
          end else if (row_hit) begin
            st_d   = ST_ARM;
            addr_d = PIN_W'(req_col);
            we_d   = !req_we;
            dqoe_d = req_we;
            dqo_d  = req_wdata;
          end else begin
            st_d   = ST_CLOSE;
            pend_d = 1'b1;
          end
        end
      end
      ST_CLOSE: begin
        if (ras_cnt >= L_RAS) begin
          ras_d               = 1'b1;
          tmr_restart[TI_RP]  = 1'b1;
          row_clr             = 1'b1;
          if (pend_q) begin
            st_d   = ST_PRECH;
            addr_d = PIN_W'(lat_row);
          end else begin
            st_d   = ST_IDLE;
          end
        end
      end
      ST_PRECH: begin
        if (rp_cnt >= L_RP) begin
          ras_d               = 1'b0;
          tmr_restart[TI_RAS] = 1'b1;
          row_set             = 1'b1;
          st_d                = ST_PREP;
        end
      end
      ST_PREP: begin
        addr_d = PIN_W'(lat_col);
        we_d   = !lat_we;
        dqoe_d = lat_we;
        dqo_d  = lat_wdata;
        st_d   = ST_ARM;
      end
      ST_ARM: begin
        if ((ras_cnt >= L_RCD) && (cp_cnt >= L_CP)) begin
          cas_d               = 1'b0;
          oe_d                = lat_we;
          tmr_restart[TI_COL] = 1'b1;
          st_d                = ST_COL;
        end
      end
      ST_COL: begin
        if (lat_we ? (col_cnt >= L_CASW)
                   : ((col_cnt >= L_COL) && (ras_cnt >= L_RAC))) begin
          cas_d              = 1'b1;
          oe_d               = 1'b1;
          we_d               = 1'b1;
          dqoe_d             = 1'b0;
          tmr_restart[TI_CP] = 1'b1;
          st_d               = ST_IDLE;
          if (!lat_we) begin
            rdv_d = 1'b1;
            rdd_d = dq_in;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pend_q    <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      mem_addr  <= '0;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      ras_n    <= ras_d;
      cas_n    <= cas_d;
      we_n     <= we_d;
      oe_n     <= oe_d;
      mem_addr <= addr_d;
      dq_oe    <= dqoe_d;
      dq_out   <= dqo_d;
      rd_valid <= rdv_d;
      rd_data  <= rdd_d;
      if (take) begin
        lat_row   <= req_row;
        lat_col   <= req_col;
        lat_we    <= req_we;
        lat_wdata <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int unsigned T_RAC      = 3,
  parameter int unsigned T_CAC      = 1,
  parameter int unsigned T_AA       = 2,
  parameter int unsigned T_OEA      = 1,
  parameter int unsigned T_RAS      = 3,
  parameter int unsigned T_RP       = 2,
  parameter int unsigned T_CP       = 1,
  parameter int unsigned T_RCD      = 1,
  parameter int unsigned T_CASW     = 1,
  parameter int unsigned T_OPEN_MAX = 500
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic rd_valid,
  input logic ref_ack,
  input logic req_ready
);
  localparam int unsigned COL_ACC = edo_ctrl_pkg::umax(edo_ctrl_pkg::umax(T_CAC, T_AA), T_OEA);
  localparam int unsigned SLACK   = T_CP + T_CASW + COL_ACC + T_RAC + T_RCD + T_RAS + 8;
  localparam logic [15:0] SAT     = 16'hFFFF;

  logic [15:0] ras_lo, ras_hi, cas_lo, cas_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo <= '0; ras_hi <= '0; cas_lo <= '0; cas_hi <= '0;
    end else begin
      ras_lo <= ras_n ? 16'd0 : ((ras_lo == SAT) ? ras_lo : ras_lo + 16'd1);
      ras_hi <= !ras_n ? 16'd0 : ((ras_hi == SAT) ? ras_hi : ras_hi + 16'd1);
      cas_lo <= cas_n ? 16'd0 : ((cas_lo == SAT) ? cas_lo : cas_lo + 16'd1);
      cas_hi <= !cas_n ? 16'd0 : ((cas_hi == SAT) ? cas_hi : cas_hi + 16'd1);
    end
  end

  p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  p_rdv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_read_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cas_lo >= 16'(COL_ACC)) && (ras_lo >= 16'(T_RAC)));
  p_bus_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  p_early_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> ($past(!we_n) && $past(dq_oe) && oe_n));
  p_ras_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo >= 16'(T_RAS)));
  p_row_prech_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi >= 16'(T_RP)));
  p_col_prech_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (cas_hi >= 16'(T_CP)));
  p_ack_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> (ras_n && cas_n && !req_ready));
  p_open_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ras_lo <= 16'(T_OPEN_MAX + SLACK));
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !req_ready);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
  .T_RAC(T_RAC), .T_CAC(T_CAC), .T_AA(T_AA), .T_OEA(T_OEA), .T_RAS(T_RAS),
  .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_CASW(T_CASW), .T_OPEN_MAX(T_OPEN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .rd_valid(rd_valid), .ref_ack(ref_ack), .req_ready(req_ready)
);

// File: tb/edo_page_ctrl_test.sv
`timescale 1ns/1ps
module edo_page_ctrl_test;
  localparam int T_RAC = 5, T_RAS = 3, T_RP = 2, T_CP = 1, T_COL = 2, T_OPEN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, ref_grant = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, dq_in = '0;
  logic        req_ready, rd_valid, ref_ack, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]  rd_data, dq_out;
  logic [10:0] mem_addr;

  edo_page_ctrl #(.T_RAC(T_RAC), .T_OPEN_MAX(T_OPEN)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_grant(ref_grant), .ref_ack(ref_ack),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .mem_addr(mem_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, ras_falls = 0;
  bit done = 1'b0;
  logic [3:0]  dram_mem [int];
  logic [3:0]  ref_mem [int];
  logic [3:0]  exp_q [$];
  logic [10:0] exp_row = '0, exp_col = '0, row_l = '0, col_l = '0;

  function automatic logic [3:0] init_val(input int key);
    return 4'(key) ^ 4'(key >> 11) ^ 4'h5;
  endfunction

  function automatic logic [3:0] dram_rd(input int key);
    return dram_mem.exists(key) ? dram_mem[key] : init_val(key);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // DRAM model: times strobes in clocks, stores writes, returns inverted data if sampled early
  bit p_ras = 1, p_cas = 1, p_we = 1, p_dqoe = 0;
  int rc = 0, hr = 0, cc = 0, hc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_we = 1; p_dqoe = 0; rc = 0; hr = 0; cc = 0; hc = 0; dq_in = '0;
    end else begin
      if (!ras_n) begin
        if (p_ras) begin
          check(hr >= T_RP, "R7 row precharge", hr, T_RP);
          check(mem_addr == exp_row, "R2 row address", mem_addr, exp_row);
          row_l = mem_addr; ras_falls++; rc = 1;
        end else rc++;
      end else begin
        if (!p_ras) begin check(rc >= T_RAS, "R6 row active", rc, T_RAS); hr = 1; end
        else hr++;
      end
      if (!cas_n) begin
        if (p_cas) begin
          check(hc >= T_CP, "R7 column precharge", hc, T_CP);
          check(mem_addr == exp_col, "R2 column address", mem_addr, exp_col);
          col_l = mem_addr; cc = 1;
          if (!we_n) begin
            check(!p_we && p_dqoe && oe_n, "R5 early write setup", {p_we, p_dqoe, oe_n}, 3'b011);
            dram_mem[{row_l, col_l}] = dq_out;
          end
        end else cc++;
      end else begin
        if (!p_cas) hc = 1; else hc++;
      end
      if (dq_oe) check(oe_n, "R5 bus driven with output enable low", oe_n, 1);
      dq_in = (!ras_n && !cas_n && !oe_n && rc >= T_RAC && cc >= T_COL)
              ? dram_rd({row_l, col_l}) : ~dram_rd({row_l, col_l});
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_dqoe = dq_oe;
    end
  end

  // read result monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected read pulse", 1, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R3/R4 read data", rd_data, e);
      end
    end
  end

  task automatic issue(input logic [10:0] r, input logic [10:0] c, input logic w, input logic [3:0] d);
    int key;
    key = {r, c};
    @(negedge clk);
    req_valid = 1'b1; req_addr = {r, c}; req_we = w; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_row = r; exp_col = c;
    if (w) ref_mem[key] = d;
    else exp_q.push_back(ref_mem.exists(key) ? ref_mem[key] : init_val(key));
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R12 ready low after acceptance", req_ready, 0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic refresh_once();
    int waited;
    @(negedge clk);
    ref_grant = 1'b1;
    @(negedge clk);
    check(!req_ready, "R10 ready low under grant", req_ready, 0);
    waited = 0;
    while (!ref_ack && waited < 40) begin @(negedge clk); waited++; end
    check(ref_ack && ras_n && cas_n, "R10 acknowledge with strobes parked",
          {ref_ack, ras_n, cas_n}, 3'b111);
    settle(3);
    ref_grant = 1'b0;
  endtask

  initial begin
    int f0;
    void'($urandom(32'd7719));
    settle(3);
    check(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dq_oe && !rd_valid, "R1 bus and read pulse idle", {dq_oe, rd_valid}, 0);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    // directed: open row 5, page hits, then a miss
    issue(11'd5, 11'd1, 1'b1, 4'h9);
    settle(6);
    f0 = ras_falls;
    issue(11'd5, 11'd2, 1'b1, 4'h3);
    issue(11'd5, 11'd1, 1'b0, 4'h0);
    issue(11'd5, 11'd2, 1'b0, 4'h0);
    settle(8);
    check(ras_falls == f0, "R8 page hits keep row strobe low", ras_falls, f0);
    check(!ras_n, "R8 row still open", ras_n, 0);
    issue(11'd9, 11'd2, 1'b0, 4'h0);
    settle(12);
    check(ras_falls == f0 + 1, "R9 miss reopens once", ras_falls, f0 + 1);
    check(row_l == 11'd9, "R9 new row strobed", row_l, 9);
    issue(11'd5, 11'd1, 1'b0, 4'h0);
    settle(12);

    // age-out of an idle open row
    settle(T_OPEN + 20);
    check(ras_n, "R11 idle row closed", ras_n, 1);

    // refresh with a row open
    issue(11'd3, 11'd7, 1'b1, 4'hC);
    settle(4);
    refresh_once();
    issue(11'd3, 11'd7, 1'b0, 4'h0);
    settle(12);

    // constrained random traffic over three rows
    for (int i = 0; i < 400; i++) begin
      logic [10:0] r, c;
      r = 11'(($urandom % 3) + 1);
      c = 11'($urandom % 8);
      issue(r, c, 1'($urandom % 2), 4'($urandom));
      settle($urandom % 4);
      if (($urandom % 40) == 0) refresh_once();
    end
    settle(30);
    check(exp_q.size() == 0, "R3 every read answered", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired (R12 progress) actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule